// File: doc/BRIEF.md
# Link Bring-Up Speed Sequencer

This controller walks a serial link through a safe bring-up order. When `start_i` pulses it writes the lowest speed code into the advertised maximum-speed field and turns link training on. Starting low keeps devices behind a switch from being missed. It then waits, with a timeout, for the link to report that it is up and no longer training. Once the link is up, the cap may be raised to generation 2. It then asks the link core for a directed speed change and polls the core's request bit until the core clears it. It checks the link a second time and reports the negotiated speed that it reads from the link status word.

Any step that runs out of time or polls sends the block to a failure path. There it raises `fail_o` and drives the receiver data-enable and PLL-enable overrides high for a fixed number of cycles, which resets the receiver. The link core's training machine is outside the block. It appears only as the status inputs.

States: IDLE, CAP (cap forced to generation 1, training off), TRAIN (wait for link), RAISE (cap set to generation 2), KICK (speed-change request pulse), GAP (wait between polls), POLL (sample the request bit), CONFIRM (wait for link again), DONE (report), RXRST (receiver override pulse). Transitions: a start moves any state to CAP. IDLE stays put. CAP always goes to TRAIN. TRAIN goes to RAISE or KICK on link-up, or to RXRST on timeout. RAISE goes to KICK, and KICK goes to GAP. GAP goes to POLL when its wait expires. POLL goes to CONFIRM when the bit reads clear, to RXRST when the polls are used up, and back to GAP otherwise. CONFIRM goes to DONE on link-up or to RXRST on timeout. DONE returns to IDLE, and so does RXRST once the hold time has run out.

Top module: `link_speed_seq`

## Requirements
- R1: After reset the max-speed output (4 bits, code 0x1 = generation 1, code 0x2 = generation 2) reads 0x1. Training enable, the request pulse, both overrides, `done_o`, `fail_o` and `final_speed_o` read 0. The max-speed output never holds any code other than 0x1 or 0x2.
- R2: In the cycle after a start is sampled, the cap reads 0x1 with training disabled. In the next cycle training is enabled and the cap is still 0x1.
- R3: The link counts as up when `link_up_i`=1 and `in_training_i`=0. At that moment the cap becomes 0x2 if `target_gen2_i`=1. Otherwise it stays at 0x1 for the rest of the run.
- R4: After link-up, `spd_chg_set_o` is high for exactly one cycle. The request bit `spd_chg_bit_i` is then sampled once every POLL_GAP+1 cycles. A sample of 0 means the change is complete.
- R5: If POLL_MAX consecutive samples all read 1, the run fails. The overrides rise POLL_MAX*(POLL_GAP+1)+1 cycles after the request pulse.
- R6: After the change completes, the link must be up again within LINK_TO cycles. Then `done_o` pulses for one cycle and `final_speed_o` takes bits [19:16] of `link_stat_i`.
- R7: If the link is not up within LINK_TO cycles of training being enabled, or after the change, the run fails. `fail_o` rises, and both overrides rise together, stay high for exactly HOLD_CYC cycles, and then fall.
- R8: A start pulse in any state, including mid-poll or in the override pulse, aborts the run and restarts from the cap step. `fail_o` clears with the restart.
- R9: `done_o` and `fail_o` are never high together. `final_speed_o` keeps its previous value on a failed run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start or restart the bring-up sequence |
| target_gen2_i | input | 1 | Configured target generation is 2 |
| link_up_i | input | 1 | Link-up status bit from the link core |
| in_training_i | input | 1 | Link-in-training status bit |
| spd_chg_bit_i | input | 1 | Readback of the speed-change request bit |
| link_stat_i | input | 32 | Link status word; bits [19:16] hold the negotiated speed |
| max_speed_o | output | 4 | Advertised maximum-speed field |
| train_en_o | output | 1 | Link training enable |
| spd_chg_set_o | output | 1 | One-cycle strobe that sets the speed-change request bit |
| rx_data_ovr_o | output | 1 | Receiver data-enable override |
| rx_pll_ovr_o | output | 1 | Receiver PLL-enable override |
| done_o | output | 1 | One-cycle pulse on successful bring-up |
| fail_o | output | 1 | Last run failed |
| final_speed_o | output | 4 | Negotiated speed from the last successful run |

## Verification
The bench builds the block with LINK_TO=64, POLL_GAP=4, POLL_MAX=200 and HOLD_CYC=50. A link timeout then takes a few dozen cycles, and the override pulse can be counted cycle by cycle. Keeping POLL_MAX at 200 means the full poll-exhaustion path takes about a thousand cycles, so it can be timed exactly. These small values let random trials mix absent partners, stuck request bits and lost links with passing runs at both target generations, and still have room for aborts in the middle of a run.

// File: rtl/lss_pkg.sv
package lss_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_CAP,
        S_TRAIN,
        S_RAISE,
        S_KICK,
        S_GAP,
        S_POLL,
        S_CONFIRM,
        S_DONE,
        S_RXRST
    } lss_state_t;

    localparam logic [3:0] SPD_CODE_G1 = 4'h1;
    localparam logic [3:0] SPD_CODE_G2 = 4'h2;
endpackage

// File: rtl/lss_timer.sv
module lss_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/link_speed_seq.sv
module link_speed_seq
    import lss_pkg::*;
#(
    parameter int LINK_TO  = 1000,
    parameter int POLL_GAP = 100,
    parameter int POLL_MAX = 200,
    parameter int HOLD_CYC = 250000,
    parameter int SPD_W    = 4,
    parameter int SPD_LSB  = 16,
    parameter int STAT_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              target_gen2_i,
    input  logic              link_up_i,
    input  logic              in_training_i,
    input  logic              spd_chg_bit_i,
    input  logic [STAT_W-1:0] link_stat_i,
    output logic [SPD_W-1:0]  max_speed_o,
    output logic              train_en_o,
    output logic              spd_chg_set_o,
    output logic              rx_data_ovr_o,
    output logic              rx_pll_ovr_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [SPD_W-1:0]  final_speed_o
);
    localparam int T_A  = (LINK_TO > POLL_GAP) ? LINK_TO : POLL_GAP;
    localparam int T_MX = (T_A > HOLD_CYC) ? T_A : HOLD_CYC;
    localparam int TW   = $clog2(T_MX + 1);
    localparam int PW   = $clog2(POLL_MAX + 1);

    lss_state_t st, nx;
    logic       link_ok;
    logic       t_ld, t_dec, t_zero;
    logic [TW-1:0] t_val;
    logic       p_ld, p_dec, p_zero;
    logic       ovr_q;
    logic       stat_unused;

    assign link_ok     = link_up_i && !in_training_i;
    assign stat_unused = ^{link_stat_i};

    // Next-state logic
    always_comb begin
        nx = st;
        if (start_i) begin
            nx = S_CAP;
        end else begin
            unique case (st)
                S_IDLE:    nx = S_IDLE;
                S_CAP:     nx = S_TRAIN;
                S_TRAIN: begin
                    if (link_ok)     nx = target_gen2_i ? S_RAISE : S_KICK;
                    else if (t_zero) nx = S_RXRST;
                end
                S_RAISE:   nx = S_KICK;
                S_KICK:    nx = S_GAP;
                S_GAP:     if (t_zero) nx = S_POLL;
                S_POLL: begin
                    if (!spd_chg_bit_i) nx = S_CONFIRM;
                    else if (p_zero)    nx = S_RXRST;
                    else                nx = S_GAP;
                end
                S_CONFIRM: begin
                    if (link_ok)     nx = S_DONE;
                    else if (t_zero) nx = S_RXRST;
                end
                S_DONE:    nx = S_IDLE;
                S_RXRST:   if (t_zero) nx = S_IDLE;
                default:   nx = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nx;
    end

    // Shared wait timer: reloaded on every state entry
    always_comb begin
        t_ld  = (nx != st);
        t_dec = !t_ld;
        unique case (nx)
            S_TRAIN, S_CONFIRM: t_val = TW'(LINK_TO - 1);
            S_GAP:              t_val = TW'(POLL_GAP - 1);
            S_RXRST:            t_val = TW'(HOLD_CYC - 1);
            default:            t_val = '0;
        endcase
    end

    lss_timer #(.W(TW)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (t_ld),
        .ld_val (t_val),
        .dec    (t_dec),
        .zero   (t_zero)
    );

    // Poll budget: loaded at the request, spent on each busy sample
    assign p_ld  = (nx == S_KICK);
    assign p_dec = (st == S_POLL) && (nx == S_GAP);

    lss_timer #(.W(PW)) u_polls (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (p_ld),
        .ld_val (PW'(POLL_MAX - 1)),
        .dec    (p_dec),
        .zero   (p_zero)
    );

    // Output registers, aligned with the state they belong to
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_speed_o   <= SPD_W'(SPD_CODE_G1);
            train_en_o    <= 1'b0;
            spd_chg_set_o <= 1'b0;
            ovr_q         <= 1'b0;
            done_o        <= 1'b0;
            fail_o        <= 1'b0;
            final_speed_o <= '0;
        end else begin
            spd_chg_set_o <= (nx == S_KICK);
            ovr_q         <= (nx == S_RXRST);
            done_o        <= (nx == S_DONE);
            if (nx == S_CAP) begin
                max_speed_o <= SPD_W'(SPD_CODE_G1);
                train_en_o  <= 1'b0;
                fail_o      <= 1'b0;
            end
            if (nx == S_TRAIN) train_en_o  <= 1'b1;
            if (nx == S_RAISE) max_speed_o <= SPD_W'(SPD_CODE_G2);
            if (nx == S_RXRST) fail_o      <= 1'b1;
            if (nx == S_DONE)  final_speed_o <= link_stat_i[SPD_LSB +: SPD_W];
        end
    end

    assign rx_data_ovr_o = ovr_q;
    assign rx_pll_ovr_o  = ovr_q;
endmodule

// File: rtl/lss_chk.sv
module lss_chk #(
    parameter int SPD_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             target_gen2_i,
    input logic             link_up_i,
    input logic             in_training_i,
    input logic [SPD_W-1:0] max_speed_o,
    input logic             train_en_o,
    input logic             spd_chg_set_o,
    input logic             done_o,
    input logic             fail_o,
    input logic             rx_data_ovr_o
);
    AST_CAP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (max_speed_o == SPD_W'(1)) || (max_speed_o == SPD_W'(2))); // R1

    AST_TRAIN_AT_G1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_en_o) |-> (max_speed_o == SPD_W'(1))); // R2

    AST_RAISE_ON_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        ((max_speed_o == SPD_W'(2)) && ($past(max_speed_o) != SPD_W'(2)))
        |-> $past(target_gen2_i && link_up_i && !in_training_i)); // R3

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        spd_chg_set_o |=> !spd_chg_set_o); // R4

    AST_DONE_AFTER_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(link_up_i && !in_training_i)); // R6

    AST_DONE_NOT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o)); // R9

    AST_OVR_FLAGS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_data_ovr_o |-> fail_o); // R7
endmodule

bind link_speed_seq lss_chk #(.SPD_W(SPD_W)) u_lss_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .target_gen2_i (target_gen2_i),
    .link_up_i     (link_up_i),
    .in_training_i (in_training_i),
    .max_speed_o   (max_speed_o),
    .train_en_o    (train_en_o),
    .spd_chg_set_o (spd_chg_set_o),
    .done_o        (done_o),
    .fail_o        (fail_o),
    .rx_data_ovr_o (rx_data_ovr_o)
);

// File: tb/link_speed_seq_test.sv
module link_speed_seq_test;
    localparam int LTO = 64;
    localparam int GAP = 4;
    localparam int PMX = 200;
    localparam int HLD = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tgt_g2 = 1'b0;
    logic        link_up = 1'b0;
    logic        chg_bit = 1'b0;
    logic        in_trn;
    logic [31:0] stat = '0;
    logic [3:0]  max_speed, final_speed;
    logic        train_en, chg_set, ovr_d, ovr_p, done, fail;

    // partner model configuration
    bit pok = 1'b0, stuck = 1'b0, cfail = 1'b0;
    int up_dly = 0, chg_dly = 1;
    int tcnt = 0, ccnt = 0;
    bit lost = 1'b0;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    assign in_trn = chg_bit;

    link_speed_seq #(
        .LINK_TO(LTO), .POLL_GAP(GAP), .POLL_MAX(PMX), .HOLD_CYC(HLD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .target_gen2_i(tgt_g2),
        .link_up_i(link_up), .in_training_i(in_trn), .spd_chg_bit_i(chg_bit),
        .link_stat_i(stat), .max_speed_o(max_speed), .train_en_o(train_en),
        .spd_chg_set_o(chg_set), .rx_data_ovr_o(ovr_d), .rx_pll_ovr_o(ovr_p),
        .done_o(done), .fail_o(fail), .final_speed_o(final_speed)
    );

    // Link core / partner model, driven away from the active edge
    always @(negedge clk) begin
        if (!rst_n || !train_en) begin
            tcnt <= 0; link_up <= 1'b0; lost <= 1'b0; chg_bit <= 1'b0;
        end else begin
            if (pok && !lost) begin
                if (tcnt >= up_dly) link_up <= 1'b1;
                else tcnt <= tcnt + 1;
            end
            if (chg_set) begin
                chg_bit <= 1'b1; ccnt <= 0;
            end else if (chg_bit && !stuck) begin
                if (ccnt + 1 >= chg_dly) begin
                    chg_bit <= 1'b0;
                    if (cfail) begin lost <= 1'b1; link_up <= 1'b0; end
                end else begin
                    ccnt <= ccnt + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_speed(input bit cfg_g2, input bit prt_g2);
        return (cfg_g2 && prt_g2) ? 2 : 1;
    endfunction

    function automatic bit exp_fail(input bit p, input bit s, input bit c);
        return !p || s || c;
    endfunction

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // One full run; checks the cap steps, the outcome and the override pulse
    task automatic run_trial(input bit g2, input bit p, input int ud, input int cd,
                             input bit s, input bit c, input bit prt_g2);
        int  prev_final;
        int  spd;
        int  n;
        bit  ef;
        spd = exp_speed(g2, prt_g2);
        tgt_g2 = g2; pok = p; up_dly = ud; chg_dly = cd; stuck = s; cfail = c;
        stat = {$urandom} & 32'hFFF0_FFFF;
        stat[19:16] = 4'(spd);
        prev_final = int'(final_speed);
        ef = exp_fail(p, s, c);
        pulse_start();
        chk(max_speed == 4'h1 && !train_en, "R2 cap step", int'(max_speed), 1);
        @(negedge clk);
        chk(max_speed == 4'h1 && train_en, "R2 train enabled at gen1", int'(train_en), 1);
        n = 0;
        while (!done && !fail && n < 4000) begin
            @(negedge clk);
            n++;
        end
        if (done) begin
            chk(!ef, "R6 success expected", 1, int'(!ef));
            chk(int'(final_speed) == spd, "R6 final speed", int'(final_speed), spd);
            chk(int'(max_speed) == (g2 ? 2 : 1), "R3 cap after link-up", int'(max_speed), g2 ? 2 : 1);
            chk(!fail, "R9 done without fail", int'(fail), 0);
            @(negedge clk);
            chk(!done, "R6 done is a pulse", int'(done), 0);
        end else if (fail) begin
            chk(ef, "R7 failure expected", 1, int'(ef));
            chk(int'(final_speed) == prev_final, "R9 speed kept on fail", int'(final_speed), prev_final);
            n = 0;
            while (ovr_d && ovr_p && n < 1000) begin
                @(negedge clk);
                n++;
            end
            chk(n == HLD, "R7 override hold length", n, HLD);
            chk(!ovr_d && !ovr_p, "R7 overrides released", int'(ovr_d), 0);
        end else begin
            chk(1'b0, "R6 run never ended", 0, 1);
        end
    endtask

    initial begin
        int k;
        int seed;
        seed = $urandom(32'h00C0_FFEE);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(max_speed == 4'h1, "R1 reset cap", int'(max_speed), 1);
        chk(!train_en && !chg_set && !ovr_d && !ovr_p, "R1 reset controls", int'(train_en), 0);
        chk(!done && !fail && final_speed == 4'h0, "R1 reset status", int'(final_speed), 0);

        // R7: link timeout timing with no partner
        tgt_g2 = 1'b0; pok = 1'b0; stuck = 1'b0; cfail = 1'b0;
        pulse_start();
        @(negedge clk);
        k = 0;
        while (!ovr_d && k < 500) begin @(negedge clk); k++; end
        chk(k == LTO, "R7 link timeout cycles", k, LTO);
        chk(fail && !done, "R7 fail flag raised", int'(fail), 1);
        k = 0;
        while (ovr_d && k < 500) begin @(negedge clk); k++; end
        chk(k == HLD, "R7 hold cycles", k, HLD);

        // R8: fail clears on restart; R4/R5 poll exhaustion timing
        pok = 1'b1; up_dly = 3; stuck = 1'b1; tgt_g2 = 1'b1;
        pulse_start();
        chk(!fail, "R8 fail cleared by start", int'(fail), 0);
        k = 0;
        while (!chg_set && k < 500) begin @(negedge clk); k++; end
        chk(max_speed == 4'h2, "R3 raised before request", int'(max_speed), 2);
        @(negedge clk);
        chk(!chg_set, "R4 request is one cycle", int'(chg_set), 0);
        k = 1;
        while (!ovr_d && k < 5000) begin @(negedge clk); k++; end
        chk(k == PMX * (GAP + 1) + 1, "R5 poll exhaustion cycles", k, PMX * (GAP + 1) + 1);
        repeat (HLD + 2) @(negedge clk);

        // R8: abort mid-poll, restart completes
        pulse_start();
        k = 0;
        while (!chg_set && k < 500) begin @(negedge clk); k++; end
        repeat (30) @(negedge clk);
        stuck = 1'b0; chg_dly = 5;
        pulse_start();
        chk(!train_en && max_speed == 4'h1 && !ovr_d, "R8 abort restarts at cap", int'(max_speed), 1);
        k = 0;
        while (!done && !fail && k < 3000) begin @(negedge clk); k++; end
        chk(done && !fail, "R8 restarted run succeeds", int'(done), 1);
        repeat (2) @(negedge clk);

        // R8: abort during override pulse
        pok = 1'b0;
        pulse_start();
        k = 0;
        while (!ovr_d && k < 500) begin @(negedge clk); k++; end
        repeat (5) @(negedge clk);
        pok = 1'b1;
        pulse_start();
        chk(!ovr_d && !fail, "R8 abort cancels override", int'(ovr_d), 0);
        k = 0;
        while (!done && !fail && k < 3000) begin @(negedge clk); k++; end
        chk(done, "R8 run after override abort", int'(done), 1);
        repeat (2) @(negedge clk);

        // R3: gen1 target with gen2-capable partner, R6 lost link on confirm
        run_trial(1'b0, 1'b1, 0, 1, 1'b0, 1'b0, 1'b1);
        run_trial(1'b1, 1'b1, 10, 20, 1'b0, 1'b1, 1'b1);
        run_trial(1'b1, 1'b1, 0, 1, 1'b0, 1'b0, 1'b1);

        // Constrained random trials
        for (int t = 0; t < 24; t++) begin
            bit g2, p, s, c, pg;
            g2 = 1'($urandom_range(0, 1));
            pg = 1'($urandom_range(0, 1));
            p  = ($urandom_range(0, 9) != 0);
            s  = ($urandom_range(0, 9) == 0);
            c  = ($urandom_range(0, 9) == 0);
            run_trial(g2, p, int'($urandom_range(0, 40)), int'($urandom_range(1, 30)), s, c, pg);
            repeat (int'($urandom_range(1, 4))) @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule